// File: doc/BRIEF.md
# Debug freeze control unit

This block takes one asynchronous debug-halt request and turns it into per-agent halt controls for three kinds of on-chip agents: a communications controller, a DMA bus master and a set of general-purpose timers. Each agent class stops with its own timing. The controller halts on the clock after the synchronised request. The DMA master first finishes any bus cycle it has already started, then gives up the bus. The timers halt one clock after the controller, and only those timers whose halt-enable bit is set in a small configuration register.

The agents themselves are outside the block and appear only as request and acknowledge signals. The controller's interrupt, memory and serial-channel requests pass through a gate. The DMA master is modelled by its bus request, the arbiter's grant, a cycle-start request and the transfer acknowledge. Each timer is modelled by its count-enable and capture-event strobes. Reset forces every halt output inactive, as if the halt request were negated.

Top module: `dbg_freeze_ctl`

## Requirements
- R1: `ctl_frz_o` goes high on the third rising clock edge after `frz_async_i` goes high: two synchroniser edges plus one register edge. It goes low with the same three-edge latency after `frz_async_i` goes low, and stays high for as long as the request is held.
- R2: While `ctl_frz_o` is high, `irq_o`, `mem_o` and `ser_o` are low. Otherwise each one equals its request input.
- R3: If a DMA bus cycle is outstanding (started through `dma_go_o` and not yet acknowledged by `dma_dtack_i`), `dma_own_o` stays high until the edge on which `dma_dtack_i` is sampled high, even when halt is active.
- R4: `dma_go_o` is high only when `dma_own_o` is high, `dma_start_i` is high, no cycle is outstanding and `ctl_frz_o` is low.
- R5: With halt active and no cycle outstanding, the DMA side drops `dma_own_o` and `dma_br_o` and holds `dma_frz_o` high until halt clears. After that it is idle for one cycle, raises `dma_br_o` again and raises `dma_own_o` only on the edge after `dma_grant_i` is sampled high while `dma_br_o` is high.
- R6: `cfg_wdata_i` is written into the halt-enable register when `cfg_we_i` is high, and `cfg_rdata_o` always shows the register. Bit i enables halting of timer i. A timer whose bit is clear is never halted and passes `tmr_cnt_i` and `tmr_cap_i` straight through.
- R7: `tmr_frz_o[i]` on a given cycle equals `ctl_frz_o` AND enable bit i on the previous cycle. While `tmr_frz_o[i]` is high, `tmr_cnt_o[i]` and `tmr_cap_o[i]` are low.
- R8: While `rst_n` is low, every halt, ownership, bus-request and start output is low and the enable register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frz_async_i | input | 1 | Asynchronous debug halt request |
| cfg_we_i | input | 1 | Enable-register write strobe |
| cfg_wdata_i | input | NTMR | Enable-register write data |
| cfg_rdata_o | output | NTMR | Enable-register contents |
| irq_req_i | input | 1 | Controller interrupt request |
| mem_req_i | input | 1 | Controller memory-access request |
| ser_req_i | input | 1 | Controller serial-channel access request |
| irq_o | output | 1 | Gated interrupt request |
| mem_o | output | 1 | Gated memory-access request |
| ser_o | output | 1 | Gated serial-channel access |
| ctl_frz_o | output | 1 | Controller halt |
| dma_breq_i | input | 1 | DMA master wants the bus |
| dma_grant_i | input | 1 | Bus grant from the arbiter |
| dma_start_i | input | 1 | DMA master wants to start a bus cycle |
| dma_dtack_i | input | 1 | Transfer acknowledge ending a bus cycle |
| dma_br_o | output | 1 | Bus request to the arbiter |
| dma_own_o | output | 1 | DMA master owns the bus |
| dma_go_o | output | 1 | Permission to start a bus cycle this clock |
| dma_frz_o | output | 1 | DMA master parked by halt |
| tmr_cnt_i | input | NTMR | Timer count-enable strobes |
| tmr_cap_i | input | NTMR | Timer capture-event strobes |
| tmr_cnt_o | output | NTMR | Gated count-enable strobes |
| tmr_cap_o | output | NTMR | Gated capture strobes |
| tmr_frz_o | output | NTMR | Per-timer halt |

## Verification
Two events can fall in the same cycle: the acknowledge of an outstanding DMA cycle and the edge on which halt becomes active. The bench provokes this by halting in the middle of a long cycle and again between cycles, and it checks that ownership drops on exactly the acknowledge edge and that no new cycle is started. A capture strobe on a timer can also coincide with the cycle on which that timer's halt takes effect. The bench holds capture strobes high across the halt edges, with a mix of enabled and disabled timers, and compares every gated strobe against a behavioural model on every clock.

// File: rtl/dfz_pkg.sv
package dfz_pkg;

  typedef enum logic [1:0] {
    DMA_IDLE = 2'd0,
    DMA_REQ  = 2'd1,
    DMA_OWN  = 2'd2,
    DMA_HALT = 2'd3
  } dma_st_e;

  // pass a request only while its agent is not halted
  function automatic logic live_pass(input logic req, input logic halted);
    return req & ~halted;
  endfunction

  // a bus cycle may be closed out: none pending, or its acknowledge arrives now
  function automatic logic cycle_clear(input logic busy, input logic ack);
    return ~busy | ack;
  endfunction

endpackage

// File: rtl/dfz_sync.sv
module dfz_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    for (genvar s = 0; s <= LAST; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[LAST];
endmodule

// File: rtl/dfz_dma_gate.sv
module dfz_dma_gate
  import dfz_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frz_act_i,
  input  logic breq_i,
  input  logic grant_i,
  input  logic start_i,
  input  logic dtack_i,
  output logic br_o,
  output logic own_o,
  output logic go_o,
  output logic halted_o,
  output logic busy_o
);
  dma_st_e st_q, st_d;
  logic    busy_q;
  logic    done;
  logic    quiet;

  assign go_o  = (st_q == DMA_OWN) & start_i & ~frz_act_i & ~busy_q;
  assign done  = busy_q & dtack_i;
  assign quiet = cycle_clear(busy_q, dtack_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      DMA_IDLE: begin
        if (frz_act_i)   st_d = DMA_HALT;
        else if (breq_i) st_d = DMA_REQ;
      end
      DMA_REQ: begin
        if (frz_act_i)    st_d = DMA_HALT;
        else if (grant_i) st_d = DMA_OWN;
      end
      DMA_OWN: begin
        if (frz_act_i && quiet)                st_d = DMA_HALT;
        else if (!breq_i && quiet && !go_o)    st_d = DMA_IDLE;
      end
      DMA_HALT: begin
        if (!frz_act_i) st_d = DMA_IDLE;
      end
      default: st_d = DMA_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DMA_IDLE;
      busy_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (done)      busy_q <= 1'b0;
      else if (go_o) busy_q <= 1'b1;
    end
  end

  assign br_o     = (st_q == DMA_REQ);
  assign own_o    = (st_q == DMA_OWN);
  assign halted_o = (st_q == DMA_HALT);
  assign busy_o   = busy_q;
endmodule

// File: rtl/dfz_tmr_gate.sv
module dfz_tmr_gate
  import dfz_pkg::*;
#(
  parameter int NTMR = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_frz_i,
  input  logic [NTMR-1:0] en_i,
  input  logic [NTMR-1:0] cnt_i,
  input  logic [NTMR-1:0] cap_i,
  output logic [NTMR-1:0] frz_o,
  output logic [NTMR-1:0] cnt_o,
  output logic [NTMR-1:0] cap_o
);
  logic [NTMR-1:0] frz_q;

  generate
    for (genvar t = 0; t < NTMR; t++) begin : g_tmr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frz_q[t] <= 1'b0;
        else        frz_q[t] <= ctl_frz_i & en_i[t];
      end
      assign cnt_o[t] = live_pass(cnt_i[t], frz_q[t]);
      assign cap_o[t] = live_pass(cap_i[t], frz_q[t]);
    end
  endgenerate

  assign frz_o = frz_q;
endmodule

// File: rtl/dbg_freeze_ctl.sv
module dbg_freeze_ctl
  import dfz_pkg::*;
#(
  parameter int NTMR        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frz_async_i,
  input  logic            cfg_we_i,
  input  logic [NTMR-1:0] cfg_wdata_i,
  output logic [NTMR-1:0] cfg_rdata_o,
  input  logic            irq_req_i,
  input  logic            mem_req_i,
  input  logic            ser_req_i,
  output logic            irq_o,
  output logic            mem_o,
  output logic            ser_o,
  output logic            ctl_frz_o,
  input  logic            dma_breq_i,
  input  logic            dma_grant_i,
  input  logic            dma_start_i,
  input  logic            dma_dtack_i,
  output logic            dma_br_o,
  output logic            dma_own_o,
  output logic            dma_go_o,
  output logic            dma_frz_o,
  input  logic [NTMR-1:0] tmr_cnt_i,
  input  logic [NTMR-1:0] tmr_cap_i,
  output logic [NTMR-1:0] tmr_cnt_o,
  output logic [NTMR-1:0] tmr_cap_o,
  output logic [NTMR-1:0] tmr_frz_o
);
  // named internal events, also watched by the checker
  logic            frz_sync;
  logic            ctl_frz_q;
  logic            dma_busy;
  logic [NTMR-1:0] en_q;

  dfz_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (frz_async_i),
    .sync_o  (frz_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_frz_q <= 1'b0;
    else        ctl_frz_q <= frz_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= '0;
    else if (cfg_we_i) en_q <= cfg_wdata_i;
  end

  assign cfg_rdata_o = en_q;
  assign ctl_frz_o   = ctl_frz_q;
  assign irq_o       = live_pass(irq_req_i, ctl_frz_q);
  assign mem_o       = live_pass(mem_req_i, ctl_frz_q);
  assign ser_o       = live_pass(ser_req_i, ctl_frz_q);

  dfz_dma_gate u_dma (
    .clk       (clk),
    .rst_n     (rst_n),
    .frz_act_i (ctl_frz_q),
    .breq_i    (dma_breq_i),
    .grant_i   (dma_grant_i),
    .start_i   (dma_start_i),
    .dtack_i   (dma_dtack_i),
    .br_o      (dma_br_o),
    .own_o     (dma_own_o),
    .go_o      (dma_go_o),
    .halted_o  (dma_frz_o),
    .busy_o    (dma_busy)
  );

  dfz_tmr_gate #(.NTMR(NTMR)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_frz_i (ctl_frz_q),
    .en_i      (en_q),
    .cnt_i     (tmr_cnt_i),
    .cap_i     (tmr_cap_i),
    .frz_o     (tmr_frz_o),
    .cnt_o     (tmr_cnt_o),
    .cap_o     (tmr_cap_o)
  );
endmodule

// File: rtl/dbg_freeze_ctl_chk.sv
module dbg_freeze_ctl_chk #(
  parameter int NTMR = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frz_sync,
  input logic            dma_busy,
  input logic            ctl_frz_o,
  input logic            irq_o,
  input logic            mem_o,
  input logic            ser_o,
  input logic            dma_own_o,
  input logic            dma_dtack_i,
  input logic            dma_go_o,
  input logic            dma_br_o,
  input logic            dma_grant_i,
  input logic            dma_frz_o,
  input logic [NTMR-1:0] tmr_frz_o,
  input logic [NTMR-1:0] tmr_cnt_o,
  input logic [NTMR-1:0] tmr_cap_o,
  input logic [NTMR-1:0] cfg_rdata_o
);
  AST_CTL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    frz_sync |=> ctl_frz_o);                                          // R1
  AST_CTL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !frz_sync |=> !ctl_frz_o);                                        // R1
  AST_CTL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_frz_o |-> !(irq_o || mem_o || ser_o));                        // R2
  AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_own_o && dma_busy && !dma_dtack_i) |=> dma_own_o);           // R3
  AST_DMA_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_frz_o |-> !dma_go_o);                                         // R4
  AST_DMA_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_own_o) |-> $past(dma_br_o && dma_grant_i));             // R5
  AST_DMA_PARK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dma_frz_o, dma_own_o, dma_br_o}));                      // R5

  generate
    for (genvar t = 0; t < NTMR; t++) begin : g_chk
      AST_TMR_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_frz_o[t] |-> $past(ctl_frz_o && cfg_rdata_o[t]));         // R7
      AST_TMR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_frz_o[t] |-> !(tmr_cnt_o[t] || tmr_cap_o[t]));            // R7
    end
  endgenerate

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RST_QUIET: assert (!ctl_frz_o && !dma_own_o && !dma_br_o && !dma_go_o
                             && !dma_frz_o && tmr_frz_o == '0 && cfg_rdata_o == '0); // R8
    end
  end
endmodule

bind dbg_freeze_ctl dbg_freeze_ctl_chk #(.NTMR(NTMR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frz_sync    (frz_sync),
  .dma_busy    (dma_busy),
  .ctl_frz_o   (ctl_frz_o),
  .irq_o       (irq_o),
  .mem_o       (mem_o),
  .ser_o       (ser_o),
  .dma_own_o   (dma_own_o),
  .dma_dtack_i (dma_dtack_i),
  .dma_go_o    (dma_go_o),
  .dma_br_o    (dma_br_o),
  .dma_grant_i (dma_grant_i),
  .dma_frz_o   (dma_frz_o),
  .tmr_frz_o   (tmr_frz_o),
  .tmr_cnt_o   (tmr_cnt_o),
  .tmr_cap_o   (tmr_cap_o),
  .cfg_rdata_o (cfg_rdata_o)
);

// File: tb/test_dbg_freeze_ctl.sv
`timescale 1ns/1ps
module test_dbg_freeze_ctl;
  localparam int NT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #4 clk = ~clk;

  logic          frz = 0, we = 0;
  logic [NT-1:0] wdata = '0;
  logic          irq_r = 0, mem_r = 0, ser_r = 0;
  logic          breq = 0, grant = 0, start = 0, dtack = 0;
  logic [NT-1:0] cnt_r = '0, cap_r = '0;

  logic [NT-1:0] rdata, cnt_g, cap_g, tfrz;
  logic          irq_g, mem_g, ser_g, cfrz, br, own, go, dfrz;

  dbg_freeze_ctl #(.NTMR(NT)) i_dbg_freeze_ctl (
    .clk(clk), .rst_n(rst_n), .frz_async_i(frz),
    .cfg_we_i(we), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .irq_req_i(irq_r), .mem_req_i(mem_r), .ser_req_i(ser_r),
    .irq_o(irq_g), .mem_o(mem_g), .ser_o(ser_g), .ctl_frz_o(cfrz),
    .dma_breq_i(breq), .dma_grant_i(grant), .dma_start_i(start), .dma_dtack_i(dtack),
    .dma_br_o(br), .dma_own_o(own), .dma_go_o(go), .dma_frz_o(dfrz),
    .tmr_cnt_i(cnt_r), .tmr_cap_i(cap_r), .tmr_cnt_o(cnt_g), .tmr_cap_o(cap_g),
    .tmr_frz_o(tfrz)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic    hist[$];
  bit      m_ctl;
  bit [NT-1:0] m_en, m_tfrz;
  int      m_st;       // 0 idle, 1 asking, 2 owning, 3 parked
  bit      m_busy;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete(); m_ctl = 0; m_en = '0; m_tfrz = '0; m_st = 0; m_busy = 0;
    end else begin
      bit c_old, g, ack, clear;
      bit [NT-1:0] e_old;
      c_old = m_ctl; e_old = m_en;
      hist.push_front(frz);
      if (hist.size() > 3) void'(hist.pop_back());
      m_ctl  = (hist.size() == 3) ? hist[2] : 1'b0;
      m_tfrz = e_old & {NT{c_old}};
      if (we) m_en = wdata;
      g     = (m_st == 2) && start && !c_old && !m_busy;
      ack   = m_busy && dtack;
      clear = !m_busy || ack;
      if (m_st == 0)      m_st = c_old ? 3 : (breq ? 1 : 0);
      else if (m_st == 1) m_st = c_old ? 3 : (grant ? 2 : 1);
      else if (m_st == 2) begin
        if (c_old && clear) m_st = 3;
        else if (!breq && clear && !g) m_st = 0;
      end else if (!c_old) m_st = 0;
      if (ack) m_busy = 0; else if (g) m_busy = 1;
    end
  end

  // ---------------- stimulus helpers ----------------
  bit grant_en = 1;
  bit want = 0;
  int ack_wait = 2, ack_cnt = 0;

  task automatic compare();
    bit e_go;
    e_go = (m_st == 2) && start && !m_ctl && !m_busy;
    chk("R1 ctl_frz", cfrz, m_ctl);
    chk("R2 irq", irq_g, irq_r && !m_ctl);
    chk("R2 mem", mem_g, mem_r && !m_ctl);
    chk("R2 ser", ser_g, ser_r && !m_ctl);
    chk("R3 own", own, m_st == 2);
    chk("R4 go", go, e_go);
    chk("R5 br", br, m_st == 1);
    chk("R5 parked", dfrz, m_st == 3);
    chk("R6 rdata", rdata, m_en);
    chk("R7 tmr_frz", tfrz, m_tfrz);
    chk("R7 cnt", cnt_g, cnt_r & ~m_tfrz);
    chk("R7 cap", cap_g, cap_r & ~m_tfrz);
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    we    = 0;
    grant = grant_en && (m_st == 1);
    start = want;
    if (m_busy) begin
      dtack = (ack_cnt >= ack_wait);
      ack_cnt++;
    end else begin
      dtack = 0; ack_cnt = 0;
    end
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  // ---------------- sequence ----------------
  initial begin
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    // R8: quiet reset state at the ports
    chk("R8 reset ctl", cfrz, 0);
    chk("R8 reset dma", {own, br, go, dfrz}, 0);
    chk("R8 reset tmr", tfrz, 0);
    chk("R8 reset rdata", rdata, 0);
    rst_n = 1;
    run(3);

    // R6: program enables 101, read back
    @(negedge clk); we = 1; wdata = 3'b101;
    run(2);
    chk("R6 readback", rdata, 3'b101);

    irq_r = 1; mem_r = 1; ser_r = 1;
    cnt_r = 3'b111; cap_r = 3'b111;
    breq = 1; want = 1; ack_wait = 9;
    run(12);

    // A: halt in the middle of a long DMA cycle (R3, R4)
    while (!m_busy) step();
    step();
    frz = 1;
    run(20);
    frz = 0;
    run(12);

    // B: halt between cycles: bus owned, no cycle started (R5, R7)
    want = 0; ack_wait = 1;
    run(12);
    frz = 1;
    run(10);
    frz = 0;
    run(10);

    // C: capture pending, enables changed during halt (R6, R7)
    want = 1; ack_wait = 2;
    cap_r = 3'b111;
    frz = 1;
    run(6);
    @(negedge clk); compare(); we = 1; wdata = 3'b010;
    run(6);
    frz = 0;
    run(8);

    // D: halt while asking for the bus, grant withheld (R5)
    want = 0; breq = 0;
    run(6);
    grant_en = 0; breq = 1;
    run(4);
    frz = 1;
    run(8);
    frz = 0;
    run(6);
    chk("R5 waits for grant", own, 0);
    grant_en = 1;
    run(6);
    chk("R5 owns after grant", own, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule